// File: doc/BRIEF.md
# Bus Clock Divider with Sleep Park

This block derives a slower clock for a downstream processor from the host bus clock. A 2-bit select picks a ratio of 1, 2, 3 or 4. The block works in half-cycles of the input clock, so every ratio, including 3, gives an output that is high for exactly half of its period. A sleep input parks the output at a steady high level, which stops the downstream processor. Releasing sleep starts a new full-length period at the selected ratio.

Changes on the select or sleep inputs take effect only at the input rising edge that begins a new output period. The output period that is running when a change arrives always completes. This prevents shortened pulses. When sleep is requested, the output finishes its current low phase before it parks high. While sleep is held, the block reconsiders its inputs once per input cycle.

The registers that hold the select and sleep controls sit outside this block and drive its inputs. They reset to a select of 01, which is divide by 2.

Top module: `divclk_gen`

## Requirements
- R1: With divSel = 2'b00 and sleep low, clkOut repeats every input cycle. It is high while clkIn is high and low while clkIn is low.
- R2: With divSel = 2'b01 and sleep low, the period of clkOut is 2 input cycles.
- R3: With divSel = 2'b10 and sleep low, the period of clkOut is 3 input cycles. It falls at the clkIn falling edge in the middle of the second input cycle.
- R4: With divSel = 2'b11 and sleep low, the period of clkOut is 4 input cycles.
- R5: While sleep is in force, clkOut stays high with no falling edge.
- R6: divSel and sleepReq are sampled only at the clkIn rising edge that starts a new output period. Every output period starts with a clkOut rising edge at a clkIn rising edge. Input changes in the middle of a period have no effect on that period.
- R7: When sleep is requested, the current output period, including its low phase, completes before clkOut parks high.
- R8: While rstN is low, clkOut is high. After reset is released, the first clkIn rising edge starts a period using the inputs present at that edge.
- R9: After sleep is released, the next period starts at a clkIn rising edge and is a full-length period at the selected ratio.
- R10: For every ratio N, clkOut is high for exactly N half-cycles of clkIn and low for N half-cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Host bus clock |
| rstN | input | 1 | Active-low reset, released synchronously to clkIn |
| divSel | input | 2 | Ratio select: 00 gives /1, 01 gives /2, 10 gives /3, 11 gives /4 |
| sleepReq | input | 1 | 1 requests the output to be parked high |
| clkOut | output | 1 | Derived clock |

## Verification
The hardest situations to reach are inputs that change in the middle of an output period, and sleep requests or releases that land on an arbitrary slot of an odd-ratio period. The bench produces these with directed sequences that change the select on every cycle, and that enter and leave sleep from divide by 4 and divide by 3. A long run of seeded random select and sleep changes follows. A bench model predicts the level of every half-cycle and compares it with clkOut. Edge-time monitors measure the period, the high time and the falling edges seen during sleep.

// File: rtl/divclk_pkg.sv
package divclk_pkg;

  // Width of the ratio select; ratio = select + 1
  localparam int SEL_W = 2;
  // Index of a half-cycle inside one output period
  localparam int HALF_W = SEL_W + 1;

  // Strobes the control hands to the datapath at each clkIn rising edge
  typedef struct packed {
    logic             park;      // cycle starting now is a sleep cycle
    logic [SEL_W-1:0] code;      // ratio code in force for this cycle
    logic [SEL_W-1:0] slotNow;   // input-cycle index of the cycle starting now
    logic [SEL_W-1:0] slotNext;  // index the following cycle will have
  } divStrobe_t;

endpackage

// File: rtl/divclk_ctrl.sv
module divclk_ctrl
  import divclk_pkg::*;
#(
  parameter logic [SEL_W-1:0] RESET_CODE = SEL_W'(1)
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             sleepReq,
  output divStrobe_t       strb
);

  logic [SEL_W-1:0] slotQ, codeQ;
  logic             parkQ;

  logic             periodEnd;
  logic             nextEnd;
  logic [SEL_W-1:0] slotD, codeD, afterD;
  logic             parkD;

  always_comb begin
    // A sleep cycle is a period of one input cycle
    periodEnd = parkQ || (slotQ == codeQ);
    if (periodEnd) begin
      parkD = sleepReq;
      codeD = divSel;
      slotD = '0;
    end else begin
      parkD = parkQ;
      codeD = codeQ;
      slotD = slotQ + 1'b1;
    end
    nextEnd = parkD || (slotD == codeD);
    afterD  = nextEnd ? '0 : (slotD + 1'b1);
  end

  assign strb = '{park: parkD, code: codeD, slotNow: slotD, slotNext: afterD};

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      slotQ <= '0;
      codeQ <= RESET_CODE;
      parkQ <= 1'b1;   // reset behaves as a finished sleep cycle
    end else begin
      slotQ <= slotD;
      codeQ <= codeD;
      parkQ <= parkD;
    end
  end

endmodule

// File: rtl/divclk_datapath.sv
module divclk_datapath
  import divclk_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  divStrobe_t strb,
  output logic       clkOut
);

  // High for the first N half-cycles of a period of 2N half-cycles
  function automatic logic halfHigh(input logic park,
                                    input logic [SEL_W-1:0] code,
                                    input logic [SEL_W-1:0] slot,
                                    input logic second);
    logic [HALF_W-1:0] halfIdx;
    halfIdx = {slot, second};
    return park || (halfIdx <= {1'b0, code});
  endfunction

  logic loD, hiD;
  logic loQ, hiPendQ, hiQ;

  always_comb begin
    loD = halfHigh(strb.park, strb.code, strb.slotNow, 1'b1);
    // Slot 0 of any period, including a sleep cycle, opens high
    if (strb.slotNext == '0) hiD = 1'b1;
    else                     hiD = halfHigh(strb.park, strb.code, strb.slotNext, 1'b0);
  end

  // Low-half level for this cycle and high-half level for the next
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      loQ     <= 1'b1;
      hiPendQ <= 1'b1;
    end else begin
      loQ     <= loD;
      hiPendQ <= hiD;
    end
  end

  // Loaded during the low half, so it is settled before it is selected
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) hiQ <= 1'b1;
    else       hiQ <= hiPendQ;
  end

  // Each source changes only while the other one is selected
  assign clkOut = clkIn ? hiQ : loQ;

endmodule

// File: rtl/divclk_gen.sv
module divclk_gen
  import divclk_pkg::*;
#(
  parameter logic [SEL_W-1:0] RESET_CODE = SEL_W'(1)
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             sleepReq,
  output logic             clkOut
);

  divStrobe_t ctrlStrb;

  divclk_ctrl #(.RESET_CODE(RESET_CODE)) ctrl_i (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .divSel   (divSel),
    .sleepReq (sleepReq),
    .strb     (ctrlStrb)
  );

  divclk_datapath dp_i (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .strb   (ctrlStrb),
    .clkOut (clkOut)
  );

endmodule

// File: rtl/divclk_gen_chk.sv
module divclk_gen_chk
  import divclk_pkg::*;
(
  input logic             clkIn,
  input logic             rstN,
  input logic [SEL_W-1:0] divSel,
  input logic             sleepReq,
  input logic             clkOut,
  input divStrobe_t       strb
);

  // R6: a period start takes the inputs present at that edge
  a_r6_sample_at_start: assert property (@(posedge clkIn) disable iff (!rstN)
    (strb.slotNow == '0) |-> (strb.park == sleepReq && strb.code == divSel));

  // R6: mode held for the rest of a period
  a_r6_hold_mid_period: assert property (@(posedge clkIn) disable iff (!rstN)
    (strb.slotNow != '0) |-> ($stable(strb.code) && $stable(strb.park)));

  // R6: slots advance one per input cycle inside a period
  a_r6_slot_step: assert property (@(posedge clkIn) disable iff (!rstN)
    (strb.slotNow != '0) |-> (strb.slotNow == $past(strb.slotNow) + 1'b1));

  // R5: a sleep cycle keeps the output high in its low half
  a_r5_park_high: assert property (@(posedge clkIn) disable iff (!rstN)
    strb.park |=> clkOut);

  // R1: divide by 1 drives the low half low
  a_r1_low_half: assert property (@(posedge clkIn) disable iff (!rstN)
    (!strb.park && strb.code == '0) |=> !clkOut);

  // R10: the last cycle of a running period ends low
  a_r10_last_low: assert property (@(posedge clkIn) disable iff (!rstN)
    (!strb.park && strb.slotNow == strb.code) |=> !clkOut);

endmodule

bind divclk_gen divclk_gen_chk chk_i (
  .clkIn    (clkIn),
  .rstN     (rstN),
  .divSel   (divSel),
  .sleepReq (sleepReq),
  .clkOut   (clkOut),
  .strb     (ctrlStrb)
);

// File: tb/divclk_gen_tb_top.sv
module divclk_gen_tb_top;

  localparam int HALF = 5;              // 100 MHz: 10 ns period
  localparam int WATCHDOG = 200000;     // input cycles

  logic       clkIn = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] divSel = 2'b01;
  logic       sleepReq = 1'b0;
  logic       clkOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #HALF clkIn = ~clkIn;

  divclk_gen dut_i (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .divSel   (divSel),
    .sleepReq (sleepReq),
    .clkOut   (clkOut)
  );

  // Edge-time monitors
  longint riseA = 0, riseB = 0, fallT = 0;
  int fallCount = 0;
  always @(posedge clkOut) begin riseA = riseB; riseB = $time; end
  always @(negedge clkOut) begin fallT = $time; fallCount = fallCount + 1; end

  // Reference model: half-cycle levels per the requirements
  int  mIdx = 0, mLen = 0, mN = 2;
  bit  mPark = 1'b1;

  function automatic string modeTag(input logic [1:0] s, input logic slp);
    if (slp) return "R5";
    case (s)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic bit expLevel(input int idx);
    return mPark || (idx < mN);
  endfunction

  task automatic checkBit(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  task automatic checkNum(input string tag, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  // Called at rising edge + 8; drives inputs, runs one input cycle
  task automatic cycle(input string tag, input logic [1:0] s, input logic slp);
    bit eHi, eLo;
    divSel   = s;
    sleepReq = slp;
    @(posedge clkIn);
    if (mIdx >= mLen) begin
      mPark = slp;
      mN    = int'(s) + 1;
      mLen  = mPark ? 2 : 2 * mN;
      mIdx  = 0;
    end
    eHi = expLevel(mIdx);
    eLo = expLevel(mIdx + 1);
    mIdx += 2;
    #2 checkBit(tag, clkOut, eHi, "high-half level");
    #5 checkBit(tag, clkOut, eLo, "low-half level");
    #1;
  endtask

  task automatic measure(input string tag, input int n);
    longint hi;
    checkNum(tag, riseB - riseA, 2 * HALF * n, "output period");
    hi = (fallT > riseB) ? (fallT - riseB) : (fallT - riseA);
    checkNum("R10", hi, HALF * n, "high time");
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clkIn);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    // R8: output high while in reset (after the first clock edge)
    #13 checkBit("R8", clkOut, 1'b1, "reset level low half");
    #4  checkBit("R8", clkOut, 1'b1, "reset level high half");
    #6  rstN = 1'b1;   // released at rising edge + 8

    // R8: first period right after release uses inputs at that edge
    cycle("R8", 2'b10, 1'b0);

    // R1..R4, R10: every ratio, measured
    for (int s = 0; s < 4; s++) begin
      repeat (24) cycle(modeTag(2'(s), 1'b0), 2'(s), 1'b0);
      measure(modeTag(2'(s), 1'b0), s + 1);
    end

    // R6: select changes in the middle of divide-by-4 periods
    repeat (8) cycle("R6", 2'b11, 1'b0);
    cycle("R6", 2'b00, 1'b0);
    cycle("R6", 2'b10, 1'b0);
    cycle("R6", 2'b01, 1'b0);
    repeat (12) cycle("R6", 2'b11, 1'b0);
    measure("R6", 4);

    // R7 then R5: sleep requested mid-period of divide by 4
    repeat (5) cycle("R7", 2'b11, 1'b0);
    repeat (6) cycle("R7", 2'b11, 1'b1);
    f0 = fallCount;
    repeat (30) cycle("R5", 2'b01, 1'b1);
    checkNum("R5", fallCount - f0, 0, "falling edges during sleep");

    // R9: release into divide by 3
    repeat (12) cycle("R9", 2'b10, 1'b0);
    measure("R9", 3);

    // R6: seeded random select and sleep traffic
    begin
      logic [1:0] s = 2'b01;
      logic       slp = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(7) == 0)  s = 2'($urandom_range(3));
        if ($urandom_range(15) == 0) slp = ~slp;
        cycle("R6", s, slp);
      end
    end

    // R3 once more from a clean start
    repeat (12) cycle("R3", 2'b10, 1'b0);
    measure("R3", 3);

    finishRun();
  end

endmodule